// File: doc/BRIEF.md
# Packed Four-Lane 16-bit Arithmetic Unit

This block is a registered datapath that treats each 64-bit operand as four independent 16-bit lanes. All four lanes are computed in the same cycle. Lane i occupies bits `[16*i+15 : 16*i]`. An operation code selects what the lanes do:

- add or subtract, with the overflow either wrapped or clamped as a signed or an unsigned 16-bit value;
- a scaled add, which shifts the first operand left or right by a small amount before adding the second operand;
- a rounded unsigned average.

Carries never pass from one lane into the next. The scaled add lets software multiply lanes by small integer or fractional constants without a multiplier. The average keeps the carry of the sum and rounds its low bit, so chained averages do not drift.

A caller presents both operands, an opcode and a 2-bit shift amount, and pulses `in_valid`. On the next clock edge the unit registers all four lane results and raises `out_valid` for one cycle. The registered result stays in place until the next valid request.

Top module: `packed_lane_alu`

## Requirements
- R1: Each 16-bit lane is computed only from the same lane of both operands. No carry or borrow crosses a lane boundary.
- R2: Opcode 0 adds lanes modulo 2^16. Opcode 3 subtracts lanes (first minus second) modulo 2^16.
- R3: Opcodes 1 (add) and 4 (subtract) treat lanes as two's-complement. A lane result above 0x7FFF becomes 0x7FFF, and one below 0x8000 (-32768) becomes 0x8000.
- R4: Opcodes 2 (add) and 5 (subtract) treat lanes as unsigned. A lane result above 0xFFFF becomes 0xFFFF, and one below zero becomes 0x0000.
- R5: Opcode 6 computes (first lane × 2^k) + second lane as signed values, with k the `shamt` field (0 to 3). It saturates as in R3, including overflow caused by the shift itself.
- R6: Opcode 7 computes (first lane arithmetically shifted right by k) + second lane as signed values, with k from `shamt`. It saturates as in R3.
- R7: Opcode 8 forms the 17-bit unsigned sum s of the two lanes. The lane result is s[16:1] with bit 0 replaced by s[1] OR s[0]. It never saturates.
- R8: `result` and `out_valid` change on the clock edge that samples `in_valid` high, one cycle of latency. While `in_valid` is low, `out_valid` is 0 and `result` holds its value.
- R9: A synchronous active-high `rst` clears `result` to zero and `out_valid` to 0.
- R10: Opcodes 9 to 15 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; operands are sampled when high |
| op | input | 4 | Operation code (0 to 8 defined) |
| shamt | input | 2 | Shift amount for the scaled adds |
| src_a | input | 64 | First operand, four 16-bit lanes |
| src_b | input | 64 | Second operand, four 16-bit lanes |
| out_valid | output | 1 | High for one cycle when `result` is new |
| result | output | 64 | Registered lane results |

## Verification
The bench places 0xFFFF + 1 in the low lane and checks that the next lane stays untouched. A design that lets the carry chain across the whole word would corrupt that lane.

It drives lanes to both saturation edges in both directions:
- signed lanes at 0x7FFF and 0x8000;
- unsigned lanes at 0xFFFF and below zero.

A unit that wraps in these cases, or that clamps unsigned results to the signed limits, returns the wrong lane value.

For the scaled adds, it uses shifts that overflow on their own and negative first operands shifted right. A logical rather than arithmetic shift, or a saturation check done only after truncating the shift, shows up as a wrong result.

For the average, it checks:
- a sum with its carry set, where dropping the carry halves the answer;
- sums whose low two bits select the rounding, where a truncating average gives an even result.

// File: rtl/lane_alu_pkg.sv
`timescale 1ns/1ps
package lane_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD    = 4'd0,
        OP_ADD_SS = 4'd1,
        OP_ADD_US = 4'd2,
        OP_SUB    = 4'd3,
        OP_SUB_SS = 4'd4,
        OP_SUB_US = 4'd5,
        OP_SHLADD = 4'd6,
        OP_SHRADD = 4'd7,
        OP_AVG    = 4'd8
    } lane_op_e;

    typedef enum logic [1:0] {
        NR_WRAP     = 2'd0,
        NR_SIGNED   = 2'd1,
        NR_UNSIGNED = 2'd2,
        NR_HALVE    = 2'd3
    } narrow_e;

endpackage

// File: rtl/lane_narrow.sv
`timescale 1ns/1ps
module lane_narrow
    import lane_alu_pkg::*;
#(
    parameter int W   = 16,
    parameter int EXT = 4
) (
    input  logic signed [W+EXT-1:0] wide,
    input  narrow_e                 mode,
    output logic        [W-1:0]     y
);
    localparam int WW = W + EXT;
    localparam logic signed [WW-1:0] SMAX = WW'((64'sd1 <<< (W - 1)) - 64'sd1);
    localparam logic signed [WW-1:0] SMIN = -SMAX - WW'(1);
    localparam logic signed [WW-1:0] UMAX = WW'((64'sd1 <<< W) - 64'sd1);

    always_comb begin
        y = wide[W-1:0];
        unique case (mode)
            NR_WRAP: y = wide[W-1:0];
            NR_SIGNED: begin
                if (wide > SMAX)      y = SMAX[W-1:0];
                else if (wide < SMIN) y = SMIN[W-1:0];
            end
            NR_UNSIGNED: begin
                if (wide < 0)         y = '0;
                else if (wide > UMAX) y = '1;
            end
            NR_HALVE: y = wide[W:1] | {{(W-1){1'b0}}, wide[0]};
            default: y = wide[W-1:0];
        endcase
    end

endmodule

// File: rtl/lane_unit.sv
`timescale 1ns/1ps
module lane_unit
    import lane_alu_pkg::*;
#(
    parameter int W     = 16,
    parameter int SHW   = 2
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  lane_op_e       op,
    input  logic [SHW-1:0] shamt,
    output logic [W-1:0]   y
);
    localparam int EXT = (1 << SHW) + 1;
    localparam int WW  = W + EXT;

    logic signed [WW-1:0] sa_w, sb_w, za_w, zb_w, wide_d;
    narrow_e              mode_d;

    always_comb begin
        sa_w   = {{EXT{a[W-1]}}, a};
        sb_w   = {{EXT{b[W-1]}}, b};
        za_w   = {{EXT{1'b0}}, a};
        zb_w   = {{EXT{1'b0}}, b};
        wide_d = '0;
        mode_d = NR_WRAP;
        case (op)
            OP_ADD:    begin wide_d = za_w + zb_w;            mode_d = NR_WRAP;     end
            OP_ADD_SS: begin wide_d = sa_w + sb_w;            mode_d = NR_SIGNED;   end
            OP_ADD_US: begin wide_d = za_w + zb_w;            mode_d = NR_UNSIGNED; end
            OP_SUB:    begin wide_d = za_w - zb_w;            mode_d = NR_WRAP;     end
            OP_SUB_SS: begin wide_d = sa_w - sb_w;            mode_d = NR_SIGNED;   end
            OP_SUB_US: begin wide_d = za_w - zb_w;            mode_d = NR_UNSIGNED; end
            OP_SHLADD: begin wide_d = (sa_w <<< shamt) + sb_w; mode_d = NR_SIGNED;  end
            OP_SHRADD: begin wide_d = (sa_w >>> shamt) + sb_w; mode_d = NR_SIGNED;  end
            OP_AVG:    begin wide_d = za_w + zb_w;            mode_d = NR_HALVE;    end
            default:   begin wide_d = '0;                     mode_d = NR_WRAP;     end
        endcase
    end

    lane_narrow #(.W(W), .EXT(EXT)) u_narrow (
        .wide (wide_d),
        .mode (mode_d),
        .y    (y)
    );

    always_comb begin
        if (op == OP_ADD_US) begin
            // R4
            us_add_floor_chk: assert (y >= a && y >= b)
                else $error("unsigned saturating add fell below an operand");
        end
        if (op == OP_SUB_US) begin
            // R4
            us_sub_ceiling_chk: assert (y <= a)
                else $error("unsigned saturating subtract exceeded minuend");
        end
        if (op == OP_ADD_SS && a[W-1] == b[W-1]) begin
            // R3
            ss_add_sign_chk: assert (y[W-1] == a[W-1])
                else $error("signed saturating add flipped sign");
        end
        if (op == OP_AVG) begin
            // R7
            avg_between_chk: assert ((y >= a || y >= b) && (y <= a || y <= b))
                else $error("average outside operand range");
        end
    end

endmodule

// File: rtl/packed_lane_alu.sv
`timescale 1ns/1ps
module packed_lane_alu
    import lane_alu_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int LANES  = 4,
    parameter int SHW    = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [3:0]                op,
    input  logic [SHW-1:0]            shamt,
    input  logic [LANE_W*LANES-1:0]   src_a,
    input  logic [LANE_W*LANES-1:0]   src_b,
    output logic                      out_valid,
    output logic [LANE_W*LANES-1:0]   result
);
    localparam int DATA_W = LANE_W * LANES;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
    } out_st_t;

    out_st_t           st_d, st_q;
    logic [DATA_W-1:0] lanes_y;
    lane_op_e          op_e;

    assign op_e = lane_op_e'(op);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_unit #(.W(LANE_W), .SHW(SHW)) u_lane (
            .a     (src_a[g*LANE_W +: LANE_W]),
            .b     (src_b[g*LANE_W +: LANE_W]),
            .op    (op_e),
            .shamt (shamt),
            .y     (lanes_y[g*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) st_d.res = lanes_y;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;

    // R8
    valid_next_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));

endmodule

// File: tb/packed_lane_alu_bench.sv
`timescale 1ns/1ps
module packed_lane_alu_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [3:0]  op;
    logic [1:0]  shamt;
    logic [63:0] src_a, src_b;
    logic        out_valid;
    logic [63:0] result;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    packed_lane_alu u_packed_lane_alu (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .shamt(shamt),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result)
    );

    function automatic logic [15:0] clamp_s(input int r);
        int t;
        t = (r > 32767) ? 32767 : ((r < -32768) ? -32768 : r);
        return t[15:0];
    endfunction

    function automatic logic [15:0] clamp_u(input int r);
        int t;
        t = (r > 65535) ? 65535 : ((r < 0) ? 0 : r);
        return t[15:0];
    endfunction

    function automatic logic [15:0] lane_ref(input int o, input int k,
                                             input logic [15:0] a, input logic [15:0] b);
        int sa, sb, ua, ub, r;
        sa = int'($signed(a)); sb = int'($signed(b));
        ua = int'(a);          ub = int'(b);
        case (o)
            0: begin r = ua + ub; return r[15:0]; end
            1: return clamp_s(sa + sb);
            2: return clamp_u(ua + ub);
            3: begin r = ua - ub; return r[15:0]; end
            4: return clamp_s(sa - sb);
            5: return clamp_u(ua - ub);
            6: return clamp_s(sa * (1 << k) + sb);
            7: return clamp_s((sa >>> k) + sb);
            8: begin r = ua + ub; r = (r >> 1) | (r & 1); return r[15:0]; end
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [63:0] model(input int o, input int k,
                                          input logic [63:0] a, input logic [63:0] b);
        logic [63:0] m;
        for (int i = 0; i < 4; i++) m[i*16 +: 16] = lane_ref(o, k, a[i*16 +: 16], b[i*16 +: 16]);
        return m;
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic issue(input int o, input int k, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        op = 4'(o); shamt = 2'(k); src_a = a; src_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run(input string tag, input int o, input int k,
                       input logic [63:0] a, input logic [63:0] b, input logic [63:0] exp);
        issue(o, k, a, b);
        chk(tag, result, exp);
        chk(tag, {63'd0, out_valid}, 64'd1);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; op = '0; shamt = '0; src_a = '0; src_b = '0;
        repeat (3) @(negedge clk);
        chk("R9 reset result", result, 64'd0);
        chk("R9 reset valid", {63'd0, out_valid}, 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_lane_isolation();
        run("R1 carry stop", 0, 0, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0001, 64'h0);
        run("R1 borrow stop", 3, 0, 64'h1234_0000_5678_0000, 64'h0000_0001_0000_0001,
            64'h1234_FFFF_5678_FFFF);
    endtask

    task automatic t_modulo();
        run("R2 add wrap", 0, 0, 64'h7FFF_FFFF_0001_8000, 64'h0001_0002_0001_8000,
            64'h8000_0001_0002_0000);
        run("R2 sub wrap", 3, 0, 64'h0000_8000_0005_1000, 64'h0001_0001_0003_2000,
            64'hFFFF_7FFF_0002_F000);
    endtask

    task automatic t_signed_sat();
        run("R3 add ss", 1, 0, 64'h7FFF_8000_0100_FFFF, 64'h0001_FFFF_0200_FFFF,
            64'h7FFF_8000_0300_FFFE);
        run("R3 sub ss", 4, 0, 64'h8000_7FFF_0010_0000, 64'h0001_FFFF_0020_8000,
            64'h8000_7FFF_FFF0_7FFF);
    endtask

    task automatic t_unsigned_sat();
        run("R4 add us", 2, 0, 64'hFFFF_8000_0010_FFF0, 64'h0001_8000_0020_000F,
            64'hFFFF_FFFF_0030_FFFF);
        run("R4 sub us", 5, 0, 64'h0001_0005_8000_0000, 64'h0002_0003_0001_FFFF,
            64'h0000_0002_7FFF_0000);
    endtask

    task automatic t_shladd();
        run("R5 shl k3 overflow", 6, 3, 64'h1000_0010_FFFF_0001, 64'h0000_0005_0000_0002,
            64'h7FFF_0085_FFF8_000A);
        run("R5 shl k2 negative", 6, 2, 64'hC000_0010_FFFF_2000, 64'h0000_0005_0000_0000,
            64'h8000_0045_FFFC_7FFF);
        run("R5 shl k1", 6, 1, 64'hFFFF_0003_0000_4000, 64'h0000_0001_0007_FFFF,
            64'hFFFE_0007_0007_7FFF);
    endtask

    task automatic t_shradd();
        run("R6 shr k1", 7, 1, 64'h8000_7FFF_0003_FFFE, 64'h0000_7FFF_0000_0000,
            64'hC000_7FFF_0001_FFFF);
        run("R6 shr k3", 7, 3, 64'h0010_FFFF_8000_0008, 64'h0001_0000_8000_FFFF,
            64'h0003_FFFF_8000_0000);
    endtask

    task automatic t_avg();
        run("R7 avg round", 8, 0, 64'hFFFF_0000_0002_0004, 64'hFFFF_0001_0003_0000,
            64'hFFFF_0001_0003_0002);
        run("R7 avg carry", 8, 2, 64'h8000_FFFE_0006_0001, 64'h8000_0000_0004_0001,
            64'h8000_7FFF_0005_0001);
    endtask

    task automatic t_unused_op();
        run("R10 op9", 9, 1, 64'h1234_5678_9ABC_DEF0, 64'h1111_2222_3333_4444, 64'h0);
        run("R10 op15", 15, 3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 64'h0);
    endtask

    task automatic t_timing_hold();
        logic [63:0] held;
        issue(0, 0, 64'h0001_0002_0003_0004, 64'h0010_0020_0030_0040);
        held = result;
        chk("R8 one-cycle result", held, 64'h0011_0022_0033_0044);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            src_a = 64'hDEAD_BEEF_0000_1111 + 64'(i); src_b = ~src_a; op = 4'(i);
            chk("R8 idle valid low", {63'd0, out_valid}, 64'd0);
            chk("R8 idle hold", result, held);
        end
    endtask

    task automatic t_sweep();
        for (int o = 0; o < 9; o++) begin
            for (int k = 0; k < 4; k++) begin
                for (int n = 0; n < 6; n++) begin
                    logic [63:0] a, b;
                    a = {$urandom(), $urandom()};
                    b = {$urandom(), $urandom()};
                    if (n == 0) begin a = 64'h7FFF_8000_FFFF_0000; b = 64'h7FFF_8000_0001_FFFF; end
                    issue(o, k, a, b);
                    chk($sformatf("R1 R2 R3 R4 R5 R6 R7 sweep op%0d k%0d", o, k),
                        result, model(o, k, a, b));
                end
            end
        end
    endtask

    task automatic t_mid_reset();
        issue(0, 0, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0005);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        chk("R9 mid reset result", result, 64'd0);
        chk("R9 mid reset valid", {63'd0, out_valid}, 64'd0);
        rst = 1'b0; in_valid = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd7));
        t_reset();
        t_lane_isolation();
        t_modulo();
        t_signed_sat();
        t_unsigned_sat();
        t_shladd();
        t_shradd();
        t_avg();
        t_unused_op();
        t_timing_hold();
        t_sweep();
        t_mid_reset();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired got hang exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule